// File: doc/BRIEF.md
# Oversampled SPI Master Engine

This block is a synchronous SPI master that moves one packet of programmable length out on MOSI and captures the same number of bits from MISO. It runs from a fast system clock. Each SPI bit takes a programmable number N of system cycles, so one fixed clock can reach many serial rates. Within each bit period SCLK holds its idle level for the first floor(N/2) cycles and its active level for the rest. MISO is sampled at one chosen cycle of the period, which lets the caller move the capture point to match the slave's output delay.

The caller sets the control inputs and raises `start_i` for one cycle while the engine is idle. The engine stores the settings, asserts chip-select, and can wait a programmable number of cycles before the first bit. It then shifts the packet MSB-first or LSB-first and releases chip-select. `done_o` pulses for one cycle when chip-select is released. The received word is right-aligned, and bits above the packet length are zero. When comparison is enabled, each sampled bit is checked against an expected word under a per-bit mask, and any masked difference sets a sticky flag that stays set until the next start.

A separate command, `pulse_i`, issues exactly one SCLK period. It leaves chip-select unchanged, keeps MOSI at 0 and shifts no data. It can be used to clock a slave out of an unknown state.

Top module: `spi_osm_master`

## Requirements
- R1: When `cfg_idle_hi_i`=0, SCLK idles low and its active level is high. When it is 1, both levels are inverted. While `busy_o` is low, `sclk_o` equals `cfg_idle_hi_i`.
- R2: One bit period lasts N system cycles, with N=`cfg_div_i`, and a value of 0 acts as 1. SCLK is at idle level for cycles 0..floor(N/2)-1 of the period and at active level for the remaining cycles.
- R3: MISO is captured at the clock edge that ends cycle S of each bit period, counted from 0. S is `cfg_samp_i` clamped to N-1. MISO at every other cycle has no effect.
- R4: `cs_o` equals `cfg_cs_act_i` from the cycle after start is accepted through the last cycle of the last bit. At all other times it carries the opposite level.
- R5: When `cfg_wait_i`=W>0, W cycles with chip-select asserted, SCLK idle and MOSI 0 come before the first bit period. When W=0, the first bit period begins in the cycle right after start.
- R6: When `cfg_lsb_first_i`=0, bit k of the packet (k=0 first) maps to word position L-1-k. When it is 1, bit k maps to position k. This mapping applies both to `tx_word_i` on MOSI and to `rx_word_o`. `rx_word_o` bits at positions L and above read 0.
- R7: MOSI takes a bit's value in the first cycle of that bit period and holds it for the whole period. MOSI is 0 in wait cycles, during a pulse command and while idle.
- R8: The packet length is L=`cfg_len_i`. A value of 0 acts as 1, and values above MAX_LEN act as MAX_LEN.
- R9: Start is accepted only while `busy_o` is low. A start asserted during a transfer does not change the waveform. `busy_o` is high from the cycle after acceptance. In the first cycle with chip-select released, `busy_o` is low and `done_o` is high for exactly one cycle, and `rx_word_o` already holds the packet.
- R10: When `cmp_en_i` is 1 at start, a sampled bit that differs from `exp_word_i` at the same position while `exp_mask_i` is 1 there sets `mismatch_o`. The flag stays set until the next start clears it. When compare is off, the flag stays 0.
- R11: `pulse_i` while idle gives N busy cycles with the same SCLK shape as one bit period. Chip-select stays inactive, MOSI stays 0, no `done_o` pulse occurs and `rx_word_o` is unchanged. If start and pulse are raised together, start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a packet transfer (idle only) |
| pulse_i | input | 1 | Issue one SCLK period without data (idle only) |
| cfg_idle_hi_i | input | 1 | SCLK idle level: 0 low, 1 high |
| cfg_cs_act_i | input | 1 | Chip-select active level |
| cfg_lsb_first_i | input | 1 | Bit order: 0 MSB first, 1 LSB first |
| cfg_div_i | input | DIV_W | System cycles per SPI bit (0 acts as 1) |
| cfg_samp_i | input | DIV_W | MISO sample cycle within a bit period |
| cfg_wait_i | input | WAIT_W | Cycles from chip-select to first bit |
| cfg_len_i | input | LEN_W | Packet length in bits |
| tx_word_i | input | MAX_LEN | Word to transmit, right-aligned |
| exp_word_i | input | MAX_LEN | Expected receive word |
| exp_mask_i | input | MAX_LEN | Per-bit compare enable |
| cmp_en_i | input | 1 | Enable receive comparison |
| miso_i | input | 1 | Serial data from slave |
| busy_o | output | 1 | Transfer or pulse in progress |
| done_o | output | 1 | One-cycle transfer completion |
| rx_word_o | output | MAX_LEN | Received word, right-aligned |
| mismatch_o | output | 1 | Sticky compare mismatch flag |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data to slave |
| cs_o | output | 1 | Chip-select |

## Verification
A wrong bit-timer count shows up in the very next cycle as an SCLK level out of place within the period, so a per-cycle comparison of SCLK, MOSI and chip-select locates it at once. A wrong bit index or order shows first on MOSI at the start of the affected bit. It shows later in `rx_word_o`, which is visible only at `done_o`. The bench therefore drives MISO to the inverse of the intended bit on every cycle except the chosen sample cycle. A sample point that is off by even one cycle then corrupts the received word, and the sticky mismatch flag records the error at completion.

// File: rtl/spi_osm_pkg.sv
package spi_osm_pkg;

  typedef enum logic [1:0] {
    OSM_IDLE  = 2'd0,
    OSM_WAIT  = 2'd1,
    OSM_BIT   = 2'd2,
    OSM_PULSE = 2'd3
  } osm_state_e;

  // cycles per bit, never below one
  function automatic int unsigned osm_eff_div(input int unsigned d);
    return (d == 0) ? 1 : d;
  endfunction

  // cycles spent at idle level at the head of a bit period
  function automatic int unsigned osm_idle_span(input int unsigned n);
    return n / 2;
  endfunction

  function automatic int unsigned osm_clamp_samp(input int unsigned s, input int unsigned n);
    return (s > n - 1) ? n - 1 : s;
  endfunction

  function automatic int unsigned osm_clamp_len(input int unsigned l, input int unsigned mx);
    if (l == 0) return 1;
    if (l > mx) return mx;
    return l;
  endfunction

  // word position of serial bit k
  function automatic int unsigned osm_bit_pos(input int unsigned k, input int unsigned len,
                                              input logic lsb_first);
    return lsb_first ? k : (len - 1 - k);
  endfunction

endpackage

// File: rtl/spi_osm_timer.sv
module spi_osm_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DIV_W-1:0] half_i,
  input  logic [DIV_W-1:0] samp_i,
  output logic             last_o,
  output logic             first_o,
  output logic             act_o,
  output logic             samp_hit_o
);

  logic [DIV_W-1:0] cnt_q;

  assign last_o     = run_i && (cnt_q == div_i - DIV_W'(1));
  assign first_o    = run_i && (cnt_q == '0);
  assign act_o      = (cnt_q >= half_i);
  assign samp_hit_o = run_i && (cnt_q == samp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (last_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + DIV_W'(1);
  end

endmodule

// File: rtl/spi_osm_datapath.sv
module spi_osm_datapath
  import spi_osm_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int LEN_W   = 6,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               lsb_i,
  input  logic [MAX_LEN-1:0] tx_i,
  input  logic [MAX_LEN-1:0] exp_i,
  input  logic [MAX_LEN-1:0] mask_i,
  input  logic               cmp_en_i,
  input  logic               samp_hit_i,
  input  logic               adv_i,
  input  logic               miso_i,
  output logic               mosi_bit_o,
  output logic               last_bit_o,
  output logic [MAX_LEN-1:0] rx_o,
  output logic               mis_o
);

  logic [LEN_W-1:0]   len_q, k_q;
  logic               lsb_q, cmp_q, mis_q;
  logic [MAX_LEN-1:0] tx_q, exp_q, mask_q, rx_q;
  logic [IDX_W-1:0]   pos;

  assign pos        = IDX_W'(osm_bit_pos(32'(k_q), 32'(len_q), lsb_q));
  assign mosi_bit_o = tx_q[pos];
  assign last_bit_o = (k_q == len_q - LEN_W'(1));
  assign rx_o       = rx_q;
  assign mis_o      = mis_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= LEN_W'(1); k_q <= '0; lsb_q <= 1'b0; cmp_q <= 1'b0;
      tx_q <= '0; exp_q <= '0; mask_q <= '0;
    end else if (load_i) begin
      len_q  <= LEN_W'(osm_clamp_len(32'(len_i), MAX_LEN));
      k_q    <= '0;
      lsb_q  <= lsb_i;
      cmp_q  <= cmp_en_i;
      tx_q   <= tx_i;
      exp_q  <= exp_i;
      mask_q <= mask_i;
    end else if (adv_i) begin
      k_q <= k_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mis_q <= 1'b0;
    else if (load_i)  mis_q <= 1'b0;
    else if (samp_hit_i && cmp_q && mask_q[pos] && (exp_q[pos] != miso_i))
      mis_q <= 1'b1;
  end

  // one capture flop per word position
  for (genvar i = 0; i < MAX_LEN; i++) begin : g_rx
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               rx_q[i] <= 1'b0;
      else if (load_i)                          rx_q[i] <= 1'b0;
      else if (samp_hit_i && (pos == IDX_W'(i))) rx_q[i] <= miso_i;
    end
  end

endmodule

// File: rtl/spi_osm_master.sv
module spi_osm_master
  import spi_osm_pkg::*;
#(
  parameter  int MAX_LEN = 32,
  parameter  int DIV_W   = 8,
  parameter  int WAIT_W  = 8,
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int IDX_W   = $clog2(MAX_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               pulse_i,
  input  logic               cfg_idle_hi_i,
  input  logic               cfg_cs_act_i,
  input  logic               cfg_lsb_first_i,
  input  logic [DIV_W-1:0]   cfg_div_i,
  input  logic [DIV_W-1:0]   cfg_samp_i,
  input  logic [WAIT_W-1:0]  cfg_wait_i,
  input  logic [LEN_W-1:0]   cfg_len_i,
  input  logic [MAX_LEN-1:0] tx_word_i,
  input  logic [MAX_LEN-1:0] exp_word_i,
  input  logic [MAX_LEN-1:0] exp_mask_i,
  input  logic               cmp_en_i,
  input  logic               miso_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [MAX_LEN-1:0] rx_word_o,
  output logic               mismatch_o,
  output logic               sclk_o,
  output logic               mosi_o,
  output logic               cs_o
);

  osm_state_e        st_q, st_d;
  logic [DIV_W-1:0]  div_q, half_q, samp_q, div_eff;
  logic [WAIT_W-1:0] wait_q, wcnt_q;
  logic              idle_q, csact_q, done_q;

  // named internal events
  logic accept_start, accept_pulse, in_bit, in_pulse, in_wait, run;
  logic tmr_last, bit_first, act_half, samp_hit;
  logic last_bit, bit_adv, xfer_end, mosi_bit;

  assign div_eff      = DIV_W'(osm_eff_div(32'(cfg_div_i)));
  assign accept_start = (st_q == OSM_IDLE) && start_i;
  assign accept_pulse = (st_q == OSM_IDLE) && !start_i && pulse_i;
  assign in_bit       = (st_q == OSM_BIT);
  assign in_pulse     = (st_q == OSM_PULSE);
  assign in_wait      = (st_q == OSM_WAIT);
  assign run          = in_bit || in_pulse;
  assign bit_adv      = in_bit && tmr_last && !last_bit;
  assign xfer_end     = in_bit && tmr_last && last_bit;

  spi_osm_timer #(.DIV_W(DIV_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .div_i     (div_q),
    .half_i    (half_q),
    .samp_i    (samp_q),
    .last_o    (tmr_last),
    .first_o   (bit_first),
    .act_o     (act_half),
    .samp_hit_o(samp_hit)
  );

  spi_osm_datapath #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (accept_start),
    .len_i     (cfg_len_i),
    .lsb_i     (cfg_lsb_first_i),
    .tx_i      (tx_word_i),
    .exp_i     (exp_word_i),
    .mask_i    (exp_mask_i),
    .cmp_en_i  (cmp_en_i),
    .samp_hit_i(samp_hit && in_bit),
    .adv_i     (bit_adv),
    .miso_i    (miso_i),
    .mosi_bit_o(mosi_bit),
    .last_bit_o(last_bit),
    .rx_o      (rx_word_o),
    .mis_o     (mismatch_o)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      OSM_IDLE: begin
        if (accept_start)      st_d = (cfg_wait_i != '0) ? OSM_WAIT : OSM_BIT;
        else if (accept_pulse) st_d = OSM_PULSE;
      end
      OSM_WAIT:  if (wcnt_q == wait_q - WAIT_W'(1)) st_d = OSM_BIT;
      OSM_BIT:   if (xfer_end) st_d = OSM_IDLE;
      OSM_PULSE: if (tmr_last) st_d = OSM_IDLE;
      default:   st_d = OSM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= OSM_IDLE;
      div_q   <= DIV_W'(1);
      half_q  <= '0;
      samp_q  <= '0;
      wait_q  <= '0;
      idle_q  <= 1'b0;
      csact_q <= 1'b0;
      wcnt_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= xfer_end;
      wcnt_q <= in_wait ? wcnt_q + WAIT_W'(1) : '0;
      if (accept_start || accept_pulse) begin
        div_q   <= div_eff;
        half_q  <= DIV_W'(osm_idle_span(32'(div_eff)));
        samp_q  <= DIV_W'(osm_clamp_samp(32'(cfg_samp_i), 32'(div_eff)));
        wait_q  <= cfg_wait_i;
        idle_q  <= cfg_idle_hi_i;
        csact_q <= cfg_cs_act_i;
      end
    end
  end

  assign busy_o = (st_q != OSM_IDLE);
  assign done_o = done_q;
  assign mosi_o = in_bit && mosi_bit;
  assign sclk_o = run ? (idle_q ^ act_half)
                      : ((st_q == OSM_IDLE) ? cfg_idle_hi_i : idle_q);
  assign cs_o   = (in_wait || in_bit) ? csact_q
                      : ((st_q == OSM_IDLE) ? ~cfg_cs_act_i : ~csact_q);

endmodule

// File: rtl/spi_osm_master_chk.sv
module spi_osm_master_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic pulse_i,
  input logic cfg_idle_hi_i,
  input logic busy_o,
  input logic done_o,
  input logic mismatch_o,
  input logic sclk_o,
  input logic mosi_o,
  input logic cs_o,
  input logic in_bit,
  input logic bit_first,
  input logic samp_hit
);

  assert_idle_sclk_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (sclk_o == cfg_idle_hi_i));

  assert_mosi_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mosi_o);

  assert_mosi_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bit && !bit_first) |-> $stable(mosi_o));

  assert_sample_in_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    samp_hit |-> (in_bit || busy_o));

  assert_cs_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(cs_o));

  assert_start_only_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(start_i) || $past(pulse_i)));

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_mismatch_in_xfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mismatch_o) |-> $past(busy_o));

endmodule

bind spi_osm_master spi_osm_master_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .pulse_i      (pulse_i),
  .cfg_idle_hi_i(cfg_idle_hi_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .mismatch_o   (mismatch_o),
  .sclk_o       (sclk_o),
  .mosi_o       (mosi_o),
  .cs_o         (cs_o),
  .in_bit       (in_bit),
  .bit_first    (bit_first),
  .samp_hit     (samp_hit)
);

// File: tb/spi_osm_master_tb.sv
`timescale 1ns/1ps
module spi_osm_master_tb;

  localparam int MAX_LEN = 32;
  localparam int DIV_W   = 8;
  localparam int WAIT_W  = 8;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, pulse_i = 0, idle_hi = 0, cs_act = 0, lsb_first = 0, cmp_en = 0, miso = 0;
  logic [DIV_W-1:0]   div = 8'd2, samp = 8'd1;
  logic [WAIT_W-1:0]  wt = '0;
  logic [LEN_W-1:0]   len = 6'd8;
  logic [MAX_LEN-1:0] tx = '0, ex = '0, mk = '0;
  logic busy, done, mis, sclk, mosi, cs;
  logic [MAX_LEN-1:0] rx;

  always #2.5 clk = ~clk;

  spi_osm_master #(.MAX_LEN(MAX_LEN), .DIV_W(DIV_W), .WAIT_W(WAIT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pulse_i(pulse_i),
    .cfg_idle_hi_i(idle_hi), .cfg_cs_act_i(cs_act), .cfg_lsb_first_i(lsb_first),
    .cfg_div_i(div), .cfg_samp_i(samp), .cfg_wait_i(wt), .cfg_len_i(len),
    .tx_word_i(tx), .exp_word_i(ex), .exp_mask_i(mk), .cmp_en_i(cmp_en), .miso_i(miso),
    .busy_o(busy), .done_o(done), .rx_word_o(rx), .mismatch_o(mis),
    .sclk_o(sclk), .mosi_o(mosi), .cs_o(cs)
  );

  typedef struct {
    logic cs, sclk, mosi, busy, done;
    bit   chk_rx;
    logic [31:0] rx;
    logic mis;
    string tag;
  } exp_t;

  exp_t q[$];
  int vectors = 0, errors = 0;
  bit ended = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic push(logic c, logic s, logic m, logic b, logic d, bit crx,
                      logic [31:0] r, logic mm, string tag);
    exp_t e;
    e.cs = c; e.sclk = s; e.mosi = m; e.busy = b; e.done = d;
    e.chk_rx = crx; e.rx = r; e.mis = mm; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares one expected item per cycle, away from the clock edge
  always @(negedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " R4"}, "cs",   32'(cs),   32'(e.cs));
      chk({e.tag, " R1"}, "sclk", 32'(sclk), 32'(e.sclk));
      chk({e.tag, " R7"}, "mosi", 32'(mosi), 32'(e.mosi));
      chk({e.tag, " R9"}, "busy", 32'(busy), 32'(e.busy));
      chk({e.tag, " R9"}, "done", 32'(done), 32'(e.done));
      if (e.chk_rx) begin
        chk({e.tag, " R6"},  "rx",  rx, e.rx);
        chk({e.tag, " R10"}, "mis", 32'(mis), 32'(e.mis));
      end
    end
  end

  // driver: runs one transfer, stepping MISO and pushing the expected pins
  task automatic run_xfer(string tag, int n, int s, int w, int l, bit lsb, bit ih, bit ca,
                          bit ce, logic [31:0] t, logic [31:0] sl, logic [31:0] e,
                          logic [31:0] m, int poke, bit both);
    int en, es, el, cyc;
    logic [31:0] lmask, rexp;
    logic mexp;
    en = (n == 0) ? 1 : n;                 // R2
    es = (s > en - 1) ? en - 1 : s;        // R3
    el = (l == 0) ? 1 : ((l > MAX_LEN) ? MAX_LEN : l);  // R8
    lmask = (el == 32) ? 32'hFFFF_FFFF : ((32'd1 << el) - 1);
    rexp = sl & lmask;
    mexp = ce && (((sl ^ e) & m & lmask) != 0);
    div = DIV_W'(n); samp = DIV_W'(s); wt = WAIT_W'(w); len = LEN_W'(l);
    lsb_first = lsb; idle_hi = ih; cs_act = ca; cmp_en = ce;
    tx = t; ex = e; mk = m;
    start_i = 1; pulse_i = both;
    @(posedge clk); @(negedge clk);
    start_i = 0; pulse_i = 0;
    cyc = 0;
    for (int i = 0; i < w; i++) begin      // R5
      miso = ~miso;
      push(ca, ih, 1'b0, 1'b1, 1'b0, 0, '0, 1'b0, {tag, " R5"});
      @(negedge clk);
      cyc++;
    end
    for (int k = 0; k < el; k++) begin
      int pos;
      pos = lsb ? k : el - 1 - k;          // R6
      for (int c = 0; c < en; c++) begin
        miso = (c == es) ? sl[pos] : ~sl[pos];
        start_i = (cyc == poke);
        push(ca, ih ^ (c >= en / 2), t[pos], 1'b1, 1'b0, 0, '0, 1'b0, {tag, " R2"});
        @(negedge clk);
        cyc++;
      end
    end
    start_i = 0;
    push(~ca, ih, 1'b0, 1'b0, 1'b1, 1, rexp, mexp, {tag, " R9"});
    @(negedge clk);
    push(~ca, ih, 1'b0, 1'b0, 1'b0, 1, rexp, mexp, {tag, " R10"});
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_pulse(string tag, int n, bit ih, bit ca, logic [31:0] rkeep, logic mkeep);
    int en;
    en = (n == 0) ? 1 : n;
    div = DIV_W'(n); idle_hi = ih; cs_act = ca;
    pulse_i = 1;
    @(posedge clk); @(negedge clk);
    pulse_i = 0;
    for (int c = 0; c < en; c++) begin     // R11
      push(~ca, ih ^ (c >= en / 2), 1'b0, 1'b1, 1'b0, 0, '0, 1'b0, {tag, " R11"});
      @(negedge clk);
    end
    push(~ca, ih, 1'b0, 1'b0, 1'b0, 1, rkeep, mkeep, {tag, " R11"});
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    idle_hi = 1; cs_act = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("reset R9", "busy", 32'(busy), 0);
    chk("reset R9", "done", 32'(done), 0);
    chk("reset R1", "sclk", 32'(sclk), 1);
    chk("reset R4", "cs",   32'(cs),   0);
    chk("reset R7", "mosi", 32'(mosi), 0);
    chk("reset R6", "rx",   rx, 0);
    @(negedge clk);
    // basic: return-low, MSB first, N=4, sample at 3
    run_xfer("t1", 4, 3, 0, 8, 0, 0, 0, 0, 32'hA5, 32'h3C, 0, 0, -1, 0);
    // return-high, LSB first, odd N, early sample, wait, compare mismatch
    run_xfer("t2", 5, 1, 3, 13, 1, 1, 1, 1, 32'h1B2D, 32'h0F0F, 32'h0F0E, 32'h1FFF, -1, 0);
    // R2 N=0 acts as 1, R3 sample clamped, R8 len 0 acts as 1
    run_xfer("t3", 0, 7, 0, 0, 0, 0, 0, 1, 32'h1, 32'h1, 32'h0, 32'h0, -1, 0);
    // full length, N=2, sample clamp, compare enabled and matching; R10 clears old flag
    run_xfer("t4", 2, 9, 1, 32, 0, 1, 0, 1, 32'hDEAD_BEEF, 32'hCAFE_F00D, 32'hCAFE_F00D,
             32'hFFFF_FFFF, -1, 0);
    // R8 length above MAX_LEN clamps; masked difference ignored
    run_xfer("t5", 3, 0, 0, 40, 1, 0, 1, 1, 32'h8000_0001, 32'h1234_5678, 32'h1234_5679,
             32'hFFFF_FFFE, -1, 0);
    // R11 pulse keeps rx and flag
    run_pulse("t6", 3, 1, 1, 32'h1234_5678, 1'b0);
    // R9 start during transfer ignored; R11 start wins over pulse
    run_xfer("t7", 4, 2, 2, 6, 0, 0, 0, 1, 32'h2A, 32'h15, 32'h15, 32'h3F, 9, 1);
    run_pulse("t8", 6, 0, 0, 32'h15, 1'b0);
    repeat (4) @(negedge clk);
    chk("end R9", "queue", 32'(q.size()), 0);
    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule